// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Instruction Sequencer

This block paces a small processor whose fetch stage and execute stage work side by side. Every instruction cycle spans four clocks. In the first clock of a cycle the fetch stage issues one read of a 16-bit word to a byte-addressed program memory with a synchronous read port. In the second clock it captures the returned word. On the final clock edge of the cycle it hands that word to the execute stage. The execute stage works on the previous word while the next one is being fetched.

The sequencer owns the fetch address. It normally steps the address by one word. When the instruction in execute is a taken branch or jump, it throws away the word it fetched in the meantime and restarts at the target. It lets the second word of a two-word instruction pass to execute as an operand, so that word is never decoded as an instruction. It jumps to fixed vectors for reset and for two interrupt priorities. The execute side here is only a stub. It reports the instruction class of the word it holds, whether a branch is taken, and the branch target, so that other logic can build the datapath around this timing.

Opcode stub encoding:
- Top nibble `0xC`: first word of a two-word instruction.
- Top nibble `0xD`: unconditional jump.
- Top nibble `0xE`: conditional branch, taken when bit 11 is 1.
- Jumps and branches take their target as bits 10:0 times two.
- Every other word is an ordinary single-word instruction.

Top module: `fxs_sequencer`

## Requirements
- R1: After reset the first instruction cycle reads address 0x0000 with the execute slot empty (`ex_valid`=0, `int_ack`=0). In every cycle `pm_rd` is high for exactly the first clock, which is the clock after `cyc_last`.
- R2: With no redirection, the fetch address grows by 2 from one instruction cycle to the next. Bit 0 of `pm_addr` is always 0.
- R3: The word fetched in cycle k is presented on `ex_word` throughout cycle k+1, with `ex_valid`=1 and its own address on `ex_pc`. Execute outputs change only on the edge that ends a cycle.
- R4: A word whose top nibble is 0xC is reported with class code 1. The next word is then presented as class code 2 (operand), with `ex_taken`=0 whatever its bits are, so the instruction occupies two cycles.
- R5: A word with top nibble 0xE and bit 11 set is reported as class code 3 with `ex_taken`=1 and `ex_target` = bits 10:0 times two. The following cycle is a bubble (`ex_valid`=0) and fetches from the target.
- R6: A word with top nibble 0xE and bit 11 clear is class code 3 with `ex_taken`=0. It costs one cycle: the next sequential word follows directly with no bubble.
- R7: A word with top nibble 0xD is class code 4 and is always taken, with the same target rule and one bubble as R5.
- R8: A pending `irq_hi` at a cycle boundary redirects the next fetch to 0x0008, inserts a bubble, and pulses `int_ack`=2'b10 for one clock. It wins over a simultaneous `irq_lo`.
- R9: A pending `irq_lo` alone redirects the next fetch to 0x0018, inserts a bubble, and pulses `int_ack`=2'b01.
- R10: An interrupt is not taken at a boundary where the execute slot holds a taken branch or jump, or the first word of a two-word instruction. It is taken at the first following boundary where neither holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_hi | input | 1 | High-priority interrupt request (level) |
| irq_lo | input | 1 | Low-priority interrupt request (level) |
| pm_rdata | input | 16 | Program memory read data, valid one clock after `pm_rd` |
| pm_rd | output | 1 | Program memory read strobe |
| pm_addr | output | 15 | Program memory byte address |
| cyc_last | output | 1 | High in the last clock of each instruction cycle |
| ex_valid | output | 1 | Execute slot holds a real word (0 = bubble) |
| ex_word | output | 16 | Word in the execute slot |
| ex_pc | output | 15 | Address of the word in the execute slot |
| ex_class | output | 3 | Class: 0 plain, 1 two-word first, 2 operand, 3 branch, 4 jump |
| ex_taken | output | 1 | Execute word redirects the fetch |
| ex_target | output | 15 | Branch or jump target address |
| int_ack | output | 2 | One-clock interrupt acceptance {high, low} |

## Verification
The program memory holds a single program that runs four kinds of stream.
- The straight-line stretches show normal stepping by 2.
- A two-word instruction is placed so its operand looks like a taken branch, and a second one has an operand that looks like a jump. This tells real decoding apart from operand pass-through.
- A conditional branch appears both not taken and taken. This separates the one-cycle cost from the two-cycle cost with its bubble.
- Interrupts are raised at three kinds of boundary: an ordinary one, one behind a taken jump, and one behind a two-word instruction. These show immediate entry, deferral, and the priority between the two requests.

// File: rtl/fxs_pkg.sv
// Package fxs_pkg
// Shared encodings for the fetch/execute sequencer: the instruction class
// reported by the execute stub and the opcode nibbles the stub recognises.
// Assumes 16-bit instruction words with the opcode in the top nibble.
package fxs_pkg;

    typedef enum logic [2:0] {
        CLS_PLAIN   = 3'd0,
        CLS_DOUBLE  = 3'd1,
        CLS_OPERAND = 3'd2,
        CLS_BRANCH  = 3'd3,
        CLS_JUMP    = 3'd4
    } instr_class_e;

    typedef enum logic [1:0] {
        NXT_SEQ,
        NXT_BRANCH,
        NXT_VEC_HI,
        NXT_VEC_LO
    } next_sel_e;

    localparam logic [3:0] OPC_DOUBLE = 4'hC;
    localparam logic [3:0] OPC_JUMP   = 4'hD;
    localparam logic [3:0] OPC_BRANCH = 4'hE;
    localparam int         COND_BIT   = 11;
    localparam int         TGT_BITS   = 11;

endpackage

// File: rtl/fxs_phase_ctr.sv
// Module fxs_phase_ctr
// Divides the clock into instruction cycles of PHASES clocks each and flags
// the read clock, the capture clock and the boundary clock.
// Assumes PHASES >= 3 so capture precedes the boundary edge.
module fxs_phase_ctr #(
    parameter int PHASES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic ph_read,
    output logic ph_capture,
    output logic ph_last
);
    localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    logic [PH_W-1:0] phase;

    // Wrap the phase count at the end of each instruction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                       phase <= phase + PH_W'(1);
    end

    assign ph_read    = (phase == '0);
    assign ph_capture = (phase == PH_W'(1));
    assign ph_last    = (phase == PH_LAST);
endmodule

// File: rtl/fxs_exec_stub.sv
// Module fxs_exec_stub
// Holds the word in the execute stage and decodes only what sequencing
// needs: class, taken flag and branch target. A word that follows the first
// word of a two-word instruction is marked as an operand and not decoded.
// Assumes load_en pulses once per instruction cycle, on the boundary clock.
module fxs_exec_stub
    import fxs_pkg::*;
#(
    parameter int PADDR_W = 15,
    parameter int WORD_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic               load_valid,
    input  logic [WORD_W-1:0]  load_word,
    input  logic [PADDR_W-1:0] load_pc,
    output logic               ex_valid,
    output logic [WORD_W-1:0]  ex_word,
    output logic [PADDR_W-1:0] ex_pc,
    output instr_class_e       ex_class,
    output logic               ex_taken,
    output logic [PADDR_W-1:0] ex_target
);
    logic       is_operand;
    logic [3:0] opc;

    // Latch the handed-over word (or a bubble) at each cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_valid   <= 1'b0;
            ex_word    <= '0;
            ex_pc      <= '0;
            is_operand <= 1'b0;
        end else if (load_en) begin
            ex_valid   <= load_valid;
            ex_word    <= load_valid ? load_word : '0;
            ex_pc      <= load_valid ? load_pc : '0;
            is_operand <= load_valid && (ex_class == CLS_DOUBLE);
        end
    end

    assign opc       = ex_word[WORD_W-1 -: 4];
    assign ex_target = PADDR_W'({ex_word[TGT_BITS-1:0], 1'b0});

    // Classify the held word and resolve the stand-in branch condition.
    always_comb begin
        ex_class = CLS_PLAIN;
        ex_taken = 1'b0;
        if (ex_valid) begin
            if (is_operand) begin
                ex_class = CLS_OPERAND;
            end else begin
                case (opc)
                    OPC_DOUBLE: ex_class = CLS_DOUBLE;
                    OPC_JUMP: begin
                        ex_class = CLS_JUMP;
                        ex_taken = 1'b1;
                    end
                    OPC_BRANCH: begin
                        ex_class = CLS_BRANCH;
                        ex_taken = ex_word[COND_BIT];
                    end
                    default: ex_class = CLS_PLAIN;
                endcase
            end
        end
    end
endmodule

// File: rtl/fxs_fetch.sv
// Module fxs_fetch
// Owns the fetch address and the prefetch buffer. At each boundary it picks
// the next address: branch target, interrupt vector, or the next word. On a
// redirect it discards the prefetched word by handing over a bubble.
// Assumes the program memory returns data one clock after the read strobe.
module fxs_fetch
    import fxs_pkg::*;
#(
    parameter int               PADDR_W   = 15,
    parameter int               WORD_W    = 16,
    parameter logic [PADDR_W-1:0] RESET_VEC = '0,
    parameter logic [PADDR_W-1:0] HI_VEC    = PADDR_W'(8),
    parameter logic [PADDR_W-1:0] LO_VEC    = PADDR_W'(24)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               boundary,
    input  logic [WORD_W-1:0]  pm_rdata,
    input  logic               ex_taken,
    input  logic [PADDR_W-1:0] ex_target,
    input  logic               ex_double,
    input  logic               irq_hi,
    input  logic               irq_lo,
    output logic [PADDR_W-1:0] fetch_pc,
    output logic               load_valid,
    output logic [WORD_W-1:0]  load_word,
    output logic [PADDR_W-1:0] load_pc,
    output logic [1:0]         int_ack
);
    localparam logic [PADDR_W-1:0] WORD_STEP = PADDR_W'(2);

    logic [WORD_W-1:0]  fetch_buf;
    logic [PADDR_W-1:0] next_pc;
    logic               irq_ok;
    next_sel_e          sel;

    assign irq_ok = !ex_taken && !ex_double;

    // Choose the source of the next fetch address, redirects first.
    always_comb begin
        if (ex_taken)              sel = NXT_BRANCH;
        else if (irq_ok && irq_hi) sel = NXT_VEC_HI;
        else if (irq_ok && irq_lo) sel = NXT_VEC_LO;
        else                       sel = NXT_SEQ;
    end

    // Map the selection to an address, keeping it word aligned.
    always_comb begin
        case (sel)
            NXT_BRANCH: next_pc = ex_target;
            NXT_VEC_HI: next_pc = HI_VEC;
            NXT_VEC_LO: next_pc = LO_VEC;
            default:    next_pc = fetch_pc + WORD_STEP;
        endcase
        next_pc[0] = 1'b0;
    end

    // Advance the fetch address at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)        fetch_pc <= RESET_VEC;
        else if (boundary) fetch_pc <= next_pc;
    end

    // Capture the word returned by the synchronous read port.
    always_ff @(posedge clk) begin
        if (!rst_n)       fetch_buf <= '0;
        else if (capture) fetch_buf <= pm_rdata;
    end

    // Pulse the interrupt acknowledge for one clock after entry.
    always_ff @(posedge clk) begin
        if (!rst_n)        int_ack <= 2'b00;
        else if (boundary) int_ack <= {sel == NXT_VEC_HI, sel == NXT_VEC_LO};
        else               int_ack <= 2'b00;
    end

    assign load_valid = (sel == NXT_SEQ);
    assign load_word  = fetch_buf;
    assign load_pc    = fetch_pc;
endmodule

// File: rtl/fxs_sequencer.sv
// Module fxs_sequencer (top)
// Two-stage fetch/execute sequencer: a phase counter paces four-clock
// instruction cycles, the fetch unit reads one word per cycle and handles
// redirects, and the execute stub classifies the word being executed.
// Assumes a synchronous-read program memory addressed in bytes.
module fxs_sequencer
    import fxs_pkg::*;
#(
    parameter int                 PHASES    = 4,
    parameter int                 PADDR_W   = 15,
    parameter int                 WORD_W    = 16,
    parameter logic [PADDR_W-1:0] RESET_VEC = '0,
    parameter logic [PADDR_W-1:0] HI_VEC    = PADDR_W'(8),
    parameter logic [PADDR_W-1:0] LO_VEC    = PADDR_W'(24)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_hi,
    input  logic               irq_lo,
    input  logic [WORD_W-1:0]  pm_rdata,
    output logic               pm_rd,
    output logic [PADDR_W-1:0] pm_addr,
    output logic               cyc_last,
    output logic               ex_valid,
    output logic [WORD_W-1:0]  ex_word,
    output logic [PADDR_W-1:0] ex_pc,
    output logic [2:0]         ex_class,
    output logic               ex_taken,
    output logic [PADDR_W-1:0] ex_target,
    output logic [1:0]         int_ack
);
    logic               ph_capture;
    logic               load_valid;
    logic [WORD_W-1:0]  load_word;
    logic [PADDR_W-1:0] load_pc;
    instr_class_e       cls;

    fxs_phase_ctr #(.PHASES(PHASES)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph_read    (pm_rd),
        .ph_capture (ph_capture),
        .ph_last    (cyc_last)
    );

    fxs_fetch #(
        .PADDR_W   (PADDR_W),
        .WORD_W    (WORD_W),
        .RESET_VEC (RESET_VEC),
        .HI_VEC    (HI_VEC),
        .LO_VEC    (LO_VEC)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (ph_capture),
        .boundary   (cyc_last),
        .pm_rdata   (pm_rdata),
        .ex_taken   (ex_taken),
        .ex_target  (ex_target),
        .ex_double  (cls == CLS_DOUBLE),
        .irq_hi     (irq_hi),
        .irq_lo     (irq_lo),
        .fetch_pc   (pm_addr),
        .load_valid (load_valid),
        .load_word  (load_word),
        .load_pc    (load_pc),
        .int_ack    (int_ack)
    );

    fxs_exec_stub #(
        .PADDR_W (PADDR_W),
        .WORD_W  (WORD_W)
    ) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (cyc_last),
        .load_valid (load_valid),
        .load_word  (load_word),
        .load_pc    (load_pc),
        .ex_valid   (ex_valid),
        .ex_word    (ex_word),
        .ex_pc      (ex_pc),
        .ex_class   (cls),
        .ex_taken   (ex_taken),
        .ex_target  (ex_target)
    );

    assign ex_class = cls;
endmodule

// File: rtl/fxs_sequencer_chk.sv
// Module fxs_sequencer_chk
// Timing properties of the sequencer seen at its ports; bound to the top.
module fxs_sequencer_chk
    import fxs_pkg::*;
#(
    parameter int                 PADDR_W = 15,
    parameter int                 WORD_W  = 16,
    parameter logic [PADDR_W-1:0] HI_VEC  = PADDR_W'(8),
    parameter logic [PADDR_W-1:0] LO_VEC  = PADDR_W'(24)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_hi,
    input logic               irq_lo,
    input logic               pm_rd,
    input logic [PADDR_W-1:0] pm_addr,
    input logic               cyc_last,
    input logic               ex_valid,
    input logic [WORD_W-1:0]  ex_word,
    input logic [PADDR_W-1:0] ex_pc,
    input logic [2:0]         ex_class,
    input logic               ex_taken,
    input logic [PADDR_W-1:0] ex_target,
    input logic [1:0]         int_ack
);
    a_r1_read_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_last |=> pm_rd);

    a_r1_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        pm_rd |=> !pm_rd);

    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_addr[0]);

    a_r3_hold_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_last |=> ($stable(ex_valid) && $stable(ex_word) && $stable(ex_pc)));

    a_r4_operand_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_last && ex_valid && ex_class == 3'(CLS_DOUBLE))
        |=> (ex_valid && ex_class == 3'(CLS_OPERAND) && !ex_taken));

    a_r5_flush_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_last && ex_taken) |=> (!ex_valid && pm_addr == $past(ex_target)));

    a_r6_not_taken_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_last && ex_valid && ex_class == 3'(CLS_BRANCH) && !ex_taken && !irq_hi && !irq_lo)
        |=> ex_valid);

    a_r8_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(int_ack));

    a_r8_hi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack[1] |-> (pm_addr == HI_VEC && !ex_valid));

    a_r9_lo_vector: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack[0] |-> (pm_addr == LO_VEC && !ex_valid));

    a_r10_defer: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_last && (ex_taken || (ex_valid && ex_class == 3'(CLS_DOUBLE))))
        |=> (int_ack == 2'b00));
endmodule

bind fxs_sequencer fxs_sequencer_chk #(
    .PADDR_W (PADDR_W),
    .WORD_W  (WORD_W),
    .HI_VEC  (HI_VEC),
    .LO_VEC  (LO_VEC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_hi    (irq_hi),
    .irq_lo    (irq_lo),
    .pm_rd     (pm_rd),
    .pm_addr   (pm_addr),
    .cyc_last  (cyc_last),
    .ex_valid  (ex_valid),
    .ex_word   (ex_word),
    .ex_pc     (ex_pc),
    .ex_class  (ex_class),
    .ex_taken  (ex_taken),
    .ex_target (ex_target),
    .int_ack   (int_ack)
);

// File: tb/fxs_sequencer_test.sv
// Scoreboard bench: the driver queues the expected execute slot and fetch
// address for every instruction cycle and raises interrupts on schedule;
// the monitor pops one item per cycle and compares it with the ports.
module fxs_sequencer_test;

    typedef struct {
        bit          valid;
        logic [14:0] pc;
        logic [15:0] word;
        logic [2:0]  cls;
        bit          taken;
        logic [14:0] tgt;
        logic [14:0] fetch;
        logic [1:0]  ack;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_hi = 1'b0;
    logic        irq_lo = 1'b0;
    logic [15:0] pm_rdata = '0;
    logic        pm_rd;
    logic [14:0] pm_addr;
    logic        cyc_last;
    logic        ex_valid;
    logic [15:0] ex_word;
    logic [14:0] ex_pc;
    logic [2:0]  ex_class;
    logic        ex_taken;
    logic [14:0] ex_target;
    logic [1:0]  int_ack;

    logic [15:0] mem [0:255];
    exp_t        exp_q[$];
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;
    bit          reported = 1'b0;
    localparam int N_CYC = 27;

    always #10 clk = ~clk;

    fxs_sequencer uut (
        .clk(clk), .rst_n(rst_n), .irq_hi(irq_hi), .irq_lo(irq_lo),
        .pm_rdata(pm_rdata), .pm_rd(pm_rd), .pm_addr(pm_addr),
        .cyc_last(cyc_last), .ex_valid(ex_valid), .ex_word(ex_word),
        .ex_pc(ex_pc), .ex_class(ex_class), .ex_taken(ex_taken),
        .ex_target(ex_target), .int_ack(int_ack)
    );

    // Synchronous-read program memory model.
    always @(posedge clk) begin
        if (pm_rd) pm_rdata <= mem[pm_addr[8:1]];
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h5000 | 16'(i);
        mem[8'h00] = 16'hD020; mem[8'h01] = 16'h1111;
        mem[8'h04] = 16'h7A08; mem[8'h05] = 16'hD030;
        mem[8'h0C] = 16'h7A18; mem[8'h0D] = 16'hD030;
        mem[8'h10] = 16'h3004; mem[8'h11] = 16'h3005;
        mem[8'h20] = 16'h3001; mem[8'h21] = 16'hC123;
        mem[8'h22] = 16'hE800; mem[8'h23] = 16'hE014;
        mem[8'h24] = 16'h3002; mem[8'h25] = 16'hE810;
        mem[8'h26] = 16'h3003; mem[8'h31] = 16'hC777;
        mem[8'h32] = 16'hD001;
    end

    task automatic check(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s", req, what);
        end
    endtask

    task automatic push(input bit v, input logic [14:0] pc, input logic [15:0] w,
                        input logic [2:0] c, input bit tk, input logic [14:0] tg,
                        input logic [14:0] f, input logic [1:0] a, input string r);
        exp_t e;
        e.valid = v; e.pc = pc; e.word = w; e.cls = c; e.taken = tk;
        e.tgt = tg; e.fetch = f; e.ack = a; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Driver: queue the expected trace, then raise interrupts on schedule.
    initial begin
        push(1, 15'h00, 16'hD020, 3'd4, 1, 15'h40, 15'h02, 2'b00, "R7");
        push(0, 15'h00, 16'h0000, 3'd0, 0, 15'h00, 15'h40, 2'b00, "R7");
        push(1, 15'h40, 16'h3001, 3'd0, 0, 15'h00, 15'h42, 2'b00, "R3");
        push(1, 15'h42, 16'hC123, 3'd1, 0, 15'h00, 15'h44, 2'b00, "R4");
        push(1, 15'h44, 16'hE800, 3'd2, 0, 15'h00, 15'h46, 2'b00, "R4");
        push(1, 15'h46, 16'hE014, 3'd3, 0, 15'h00, 15'h48, 2'b00, "R6");
        push(1, 15'h48, 16'h3002, 3'd0, 0, 15'h00, 15'h4A, 2'b00, "R6");
        push(1, 15'h4A, 16'hE810, 3'd3, 1, 15'h20, 15'h4C, 2'b00, "R5");
        push(0, 15'h00, 16'h0000, 3'd0, 0, 15'h00, 15'h20, 2'b00, "R5");
        push(1, 15'h20, 16'h3004, 3'd0, 0, 15'h00, 15'h22, 2'b00, "R2");
        push(1, 15'h22, 16'h3005, 3'd0, 0, 15'h00, 15'h24, 2'b00, "R2");
        push(0, 15'h00, 16'h0000, 3'd0, 0, 15'h00, 15'h18, 2'b01, "R9");
        push(1, 15'h18, 16'h7A18, 3'd0, 0, 15'h00, 15'h1A, 2'b00, "R9");
        push(1, 15'h1A, 16'hD030, 3'd4, 1, 15'h60, 15'h1C, 2'b00, "R7");
        push(0, 15'h00, 16'h0000, 3'd0, 0, 15'h00, 15'h60, 2'b00, "R10");
        push(0, 15'h00, 16'h0000, 3'd0, 0, 15'h00, 15'h08, 2'b10, "R8");
        push(1, 15'h08, 16'h7A08, 3'd0, 0, 15'h00, 15'h0A, 2'b00, "R8");
        push(1, 15'h0A, 16'hD030, 3'd4, 1, 15'h60, 15'h0C, 2'b00, "R7");
        push(0, 15'h00, 16'h0000, 3'd0, 0, 15'h00, 15'h60, 2'b00, "R7");
        push(1, 15'h60, 16'h5030, 3'd0, 0, 15'h00, 15'h62, 2'b00, "R3");
        push(1, 15'h62, 16'hC777, 3'd1, 0, 15'h00, 15'h64, 2'b00, "R4");
        push(1, 15'h64, 16'hD001, 3'd2, 0, 15'h00, 15'h66, 2'b00, "R10");
        push(0, 15'h00, 16'h0000, 3'd0, 0, 15'h00, 15'h18, 2'b01, "R10");
        push(1, 15'h18, 16'h7A18, 3'd0, 0, 15'h00, 15'h1A, 2'b00, "R9");
        push(1, 15'h1A, 16'hD030, 3'd4, 1, 15'h60, 15'h1C, 2'b00, "R7");
        push(0, 15'h00, 16'h0000, 3'd0, 0, 15'h00, 15'h60, 2'b00, "R7");
        push(1, 15'h60, 16'h5030, 3'd0, 0, 15'h00, 15'h62, 2'b00, "R2");
        wait (rst_n);
        for (int c = 1; c <= N_CYC; c++) begin
            do @(negedge clk); while (!cyc_last);
            @(negedge clk);
            case (c)
                11: irq_lo = 1'b1;
                12: irq_lo = 1'b0;
                14: begin irq_hi = 1'b1; irq_lo = 1'b1; end
                16: begin irq_hi = 1'b0; irq_lo = 1'b0; end
                21: irq_lo = 1'b1;
                23: irq_lo = 1'b0;
                default: ;
            endcase
        end
    end

    // Reset, then monitor: one comparison per instruction cycle.
    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state in the first instruction cycle.
        check(pm_rd === 1'b1 && pm_addr === 15'h0 && ex_valid === 1'b0 &&
              int_ack === 2'b00 && cyc_last === 1'b0, "R1",
              $sformatf("reset state rd=%b addr=%h valid=%b ack=%b exp rd=1 addr=0000 valid=0 ack=00",
                        pm_rd, pm_addr, ex_valid, int_ack));
        while (exp_q.size() > 0) begin
            exp_t e;
            do @(negedge clk); while (!cyc_last);
            @(negedge clk);
            e = exp_q.pop_front();
            check(pm_rd === 1'b1 && pm_addr === e.fetch && int_ack === e.ack,
                  (e.req == "R3" || e.req == "R2") ? "R2" : e.req,
                  $sformatf("fetch rd=%b addr=%h ack=%b exp rd=1 addr=%h ack=%b",
                            pm_rd, pm_addr, int_ack, e.fetch, e.ack));
            if (e.valid)
                check(ex_valid === 1'b1 && ex_pc === e.pc && ex_word === e.word &&
                      ex_class === e.cls && ex_taken === e.taken &&
                      (!e.taken || ex_target === e.tgt), e.req,
                      $sformatf("exec v=%b pc=%h w=%h cls=%0d tk=%b tgt=%h exp v=1 pc=%h w=%h cls=%0d tk=%b tgt=%h",
                                ex_valid, ex_pc, ex_word, ex_class, ex_taken, ex_target,
                                e.pc, e.word, e.cls, e.taken, e.tgt));
            else
                check(ex_valid === 1'b0 && ex_taken === 1'b0, e.req,
                      $sformatf("bubble v=%b tk=%b exp v=0 tk=0", ex_valid, ex_taken));
        end
        done = 1'b1;
        report();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete, got done=0 exp done=1");
            report();
        end
    end

endmodule